// File: doc/BRIEF.md
# Register-Configured SPI Master Core

This block is a full-duplex SPI master that moves 8-bit words. Software sets it up through four 32-bit registers: a configuration word, a clock word, an interrupt-enable word and a sticky status word. A shared bus with a write strobe, a 2-bit word address and a read port reaches them. Bytes to send arrive on a ready/valid stream. Each byte shifted in from the slave leaves on a second valid/ready stream through a single holding register.

SCLK runs at a programmable fraction of the system clock. The clock word holds a divisor and a run enable. Clearing the enable freezes the serial interface wherever it stands. Changing the divisor takes three writes: clear the enable, write the divisor, set the enable again.

The one hardware chip-select falls when a frame starts. It stays low for as long as the transmit stream keeps supplying bytes back to back, and then rises. A discard count can drop the first few received bytes of every frame, for example command bytes during which the slave returns nothing useful.

Top module: `spi_master_core`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, rx_valid is 0 and all four registers read 0.
- R2: Configuration word (address 0) holds master enable at bit 0, slave select at bit 1, MSB-first at bit 2, mode at bits 5:4 and discard count at bits 10:8. A frame starts, and tx_ready goes high, only when master is 1, slave is 0 and the clock enable is 1.
- R3: The mode value equals CPOL*2+CPHA. SCLK rests at CPOL whenever cs_n is high. With CPHA=0, MISO is sampled on the first edge of each bit. With CPHA=1, it is sampled on the second edge.
- R4: With bit 2 set, bytes shift MSB first on both MOSI and MISO. With bit 2 clear, they shift LSB first.
- R5: Each byte sent on MOSI is the byte accepted on the transmit stream. The byte returned on rx_data is the 8 bits read from MISO at the same time.
- R6: Clock word (address 1) holds the divisor at bits 9:0 and the enable at bit 16. The SCLK half-period is max(1, ceil(divisor/2)) system clocks. cs_n falls one half-period before the first SCLK edge and rises one half-period after the last one.
- R7: A byte offered on the last edge of the current byte continues the frame with no gap and no chip-select pulse. Without such a byte, the frame ends.
- R8: Within a frame, the first N received bytes are not delivered on the receive stream, where N is the discard count.
- R9: While the clock enable is 0, sclk, mosi and cs_n hold their values and no bit is shifted. Setting the enable again resumes the byte correctly.
- R10: A write to the divisor field while the enable bit is already set has no effect on the divisor.
- R11: Status (address 3) bit 0 is set when a received byte is taken from the receive stream. Bit 1 is set when cs_n rises at the end of a frame. Both bits stay set until 1 is written to them. Interrupt enable (address 2) bit 0 and bit 1 gate the matching status bits onto irq.
- R12: rx_valid stays high with rx_data stable until rx_ready is seen. A byte completed while the holding register is still full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit byte accepted this cycle |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Slave data in |
| cs_n | output | 1 | Active-low chip-select |

## Verification
The bench builds the core with its default parameters: a 10-bit divisor and 8-bit words. The full divisor range is therefore reachable. A divisor of 0 or 1 gives the one-clock half-period, with SCLK toggling every cycle. A divisor of 0x3FF gives the longest half-period of 512 clocks. A behavioural slave in the bench follows all four modes and both bit orders. Random frames of several bytes run back to back, and directed cases cover discard, freezing the clock mid-byte, receive back-pressure and the divisor-write guard.

// File: rtl/spi_core_pkg.sv
`timescale 1ns/1ps
package spi_core_pkg;
  localparam int CFG_DISC_W = 3;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CLK  = 2'd1;
  localparam logic [1:0] ADDR_IE   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CLK_EN_BIT = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_TRAIL = 2'd2
  } xfer_state_t;

  typedef struct packed {
    logic                  master;
    logic                  slave;
    logic                  msb_first;
    logic [1:0]            mode;
    logic [CFG_DISC_W-1:0] discard;
  } core_cfg_t;
endpackage

// File: rtl/spi_cfg_regs.sv
`timescale 1ns/1ps
module spi_cfg_regs
  import spi_core_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             rx_idle_evt,
  input  logic             tx_idle_evt,
  output logic [31:0]      rdata,
  output core_cfg_t        cfg,
  output logic [DIV_W-1:0] div,
  output logic             clk_en,
  output logic [1:0]       stat,
  output logic             irq
);
  core_cfg_t        cfg_q, cfg_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             en_q, en_d;
  logic [1:0]       ie_q, ie_d, st_q, st_d;

  always_comb begin
    cfg_d = cfg_q;
    div_d = div_q;
    en_d  = en_q;
    ie_d  = ie_q;
    st_d  = st_q;
    if (wr_en) begin
      case (addr)
        ADDR_CFG: begin
          cfg_d.master    = wdata[0];
          cfg_d.slave     = wdata[1];
          cfg_d.msb_first = wdata[2];
          cfg_d.mode      = wdata[5:4];
          cfg_d.discard   = wdata[8 +: CFG_DISC_W];
        end
        ADDR_CLK: begin
          en_d = wdata[CLK_EN_BIT];
          if (!en_q) div_d = wdata[DIV_W-1:0];
        end
        ADDR_IE:   ie_d = wdata[1:0];
        default:   st_d = st_q & ~wdata[1:0];
      endcase
    end
    st_d = st_d | {tx_idle_evt, rx_idle_evt};
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CFG: begin
        rdata[0]                = cfg_q.master;
        rdata[1]                = cfg_q.slave;
        rdata[2]                = cfg_q.msb_first;
        rdata[5:4]              = cfg_q.mode;
        rdata[8 +: CFG_DISC_W]  = cfg_q.discard;
      end
      ADDR_CLK: begin
        rdata[DIV_W-1:0]  = div_q;
        rdata[CLK_EN_BIT] = en_q;
      end
      ADDR_IE: rdata[1:0] = ie_q;
      default: rdata[1:0] = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
      en_q  <= 1'b0;
      ie_q  <= '0;
      st_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      div_q <= div_d;
      en_q  <= en_d;
      ie_q  <= ie_d;
      st_q  <= st_d;
    end
  end

  assign cfg    = cfg_q;
  assign div    = div_q;
  assign clk_en = en_q;
  assign stat   = st_q;
  assign irq    = |(st_q & ie_q);
endmodule

// File: rtl/spi_sclk_tick.sv
`timescale 1ns/1ps
module spi_sclk_tick #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W:0]   sum;
  logic [DIV_W-1:0] half, cnt_q, cnt_d;

  always_comb begin
    sum  = {1'b0, div} + 1'b1;
    half = sum[DIV_W:1];
    if (half == '0) half = 1;
    tick = run && en && (cnt_q == half - 1'b1);
    if (!run)      cnt_d = '0;
    else if (!en)  cnt_d = cnt_q;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
  import spi_core_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  start_ok,
  input  logic                  msb_first,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic [CFG_DISC_W-1:0] discard,
  input  logic                  tx_valid,
  input  logic [WORD_W-1:0]     tx_data,
  output logic                  tx_ready,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [WORD_W-1:0]     rx_data,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  cs_n,
  output logic                  run,
  output logic                  rx_idle_evt,
  output logic                  tx_idle_evt
);
  localparam int EDGES  = 2 * WORD_W;
  localparam int EDGE_W = $clog2(EDGES);

  xfer_state_t           st_q, st_d;
  logic [EDGE_W-1:0]     edge_q, edge_d;
  logic [WORD_W-1:0]     txs_q, txs_d, rxs_q, rxs_d, rxn, rxd_q, rxd_d;
  logic [CFG_DISC_W-1:0] disc_q, disc_d;
  logic                  mosi_q, mosi_d, sclk_q, sclk_d, cs_q, cs_d, rxv_q, rxv_d;
  logic                  xtick, last_edge, sample_now, shift_now, load;
  logic [WORD_W:0]       pop_cur, pop_new;

  function automatic logic [WORD_W:0] pop_bit(input logic [WORD_W-1:0] v, input logic msb);
    if (msb) pop_bit = {v[WORD_W-1], v << 1};
    else     pop_bit = {v[0], v >> 1};
  endfunction

  always_comb begin
    xtick      = tick && (st_q == ST_XFER);
    last_edge  = xtick && (edge_q == EDGE_W'(EDGES - 1));
    sample_now = xtick && (~edge_q[0] ^ cpha);
    shift_now  = xtick && !(~edge_q[0] ^ cpha);
    tx_ready   = start_ok && ((st_q == ST_IDLE) || last_edge);
    load       = tx_ready && tx_valid;
    pop_cur    = pop_bit(txs_q, msb_first);
    pop_new    = pop_bit(tx_data, msb_first);
    rxn        = rxs_q;
    if (sample_now)
      rxn = msb_first ? {rxs_q[WORD_W-2:0], miso} : {miso, rxs_q[WORD_W-1:1]};

    st_d   = st_q;   edge_d = edge_q; txs_d = txs_q;  rxs_d = rxn;
    disc_d = disc_q; mosi_d = mosi_q; cs_d  = cs_q;   rxd_d = rxd_q;
    sclk_d = sclk_q;
    rx_idle_evt = rxv_q && rx_ready;
    tx_idle_evt = 1'b0;
    rxv_d = rxv_q && !rx_ready;

    if (shift_now) begin
      mosi_d = pop_cur[WORD_W];
      txs_d  = pop_cur[WORD_W-1:0];
    end
    if (xtick) begin
      sclk_d = ~sclk_q;
      edge_d = edge_q + 1'b1;
    end

    case (st_q)
      ST_IDLE: begin
        sclk_d = cpol;
        disc_d = discard;
      end
      ST_XFER: begin
        if (last_edge) begin
          if (disc_q != '0) disc_d = disc_q - 1'b1;
          else if (!rxv_q || rx_ready) begin
            rxv_d = 1'b1;
            rxd_d = rxn;
          end
          if (!load) st_d = ST_TRAIL;
        end
      end
      default: begin
        if (tick) begin
          st_d        = ST_IDLE;
          cs_d        = 1'b1;
          tx_idle_evt = 1'b1;
        end
      end
    endcase

    if (load) begin
      st_d   = ST_XFER;
      cs_d   = 1'b0;
      edge_d = '0;
      if (!cpha) begin
        mosi_d = pop_new[WORD_W];
        txs_d  = pop_new[WORD_W-1:0];
      end else begin
        txs_d  = tx_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      edge_q <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
      rxd_q  <= '0;
      disc_q <= '0;
      mosi_q <= 1'b0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      rxv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      edge_q <= edge_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      rxd_q  <= rxd_d;
      disc_q <= disc_d;
      mosi_q <= mosi_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      rxv_q  <= rxv_d;
    end
  end

  assign run      = (st_q != ST_IDLE);
  assign sclk     = sclk_q;
  assign mosi     = mosi_q;
  assign cs_n     = cs_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
endmodule

// File: rtl/spi_master_core.sv
`timescale 1ns/1ps
module spi_master_core
  import spi_core_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic [1:0]       rst_sync;
  logic             srst_n;
  core_cfg_t        cfg;
  logic [DIV_W-1:0] div;
  logic             clk_en, tick, run, start_ok, rx_evt, tx_evt;
  logic [1:0]       stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  assign start_ok = cfg.master && !cfg.slave && clk_en;

  spi_cfg_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rx_idle_evt(rx_evt), .tx_idle_evt(tx_evt),
    .rdata(reg_rdata), .cfg(cfg), .div(div), .clk_en(clk_en),
    .stat(stat), .irq(irq)
  );

  spi_sclk_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(srst_n), .run(run), .en(clk_en), .div(div), .tick(tick)
  );

  spi_shift_engine #(.WORD_W(WORD_W)) u_eng (
    .clk(clk), .rst_n(srst_n), .tick(tick), .start_ok(start_ok),
    .msb_first(cfg.msb_first), .cpol(cfg.mode[1]), .cpha(cfg.mode[0]),
    .discard(cfg.discard), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .run(run), .rx_idle_evt(rx_evt), .tx_idle_evt(tx_evt)
  );
endmodule

// File: rtl/spi_core_checker.sv
`timescale 1ns/1ps
module spi_core_checker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              clk_en,
  input logic              cfg_master,
  input logic              cfg_slave,
  input logic [1:0]        cfg_mode,
  input logic [1:0]        stat
);
  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |-> (cfg_master && !cfg_slave && clk_en));

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $stable(cfg_mode)) |-> (sclk == cfg_mode[1]));

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !cs_n) |=> ($stable(sclk) && $stable(mosi) && $stable(cs_n)));

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R11
  frame_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> stat[1]);
endmodule

bind spi_master_core spi_core_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .clk_en(clk_en),
  .cfg_master(cfg.master), .cfg_slave(cfg.slave), .cfg_mode(cfg.mode),
  .stat(stat)
);

// File: tb/sim_spi_master_core.sv
`timescale 1ns/1ps
module sim_spi_master_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, tx_ready, rx_valid, sclk, mosi, cs_n;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        rx_ready = 1'b1;
  logic [7:0]  rx_data;
  logic        miso_r = 1'b0;

  always #2.5 clk = ~clk;

  spi_master_core u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso_r), .cs_n(cs_n)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] tx_q [16];
  logic [7:0] sl_q [16];
  logic [7:0] cap_q [16];
  logic [7:0] rx_got [16];
  int n_cap = 0, n_rx = 0, sl_idx = 0, ec = 0, oi = 0, cyc = 0, last_evt = 0;
  int gmin = 0, gmax = 0, edges = 0, cs_falls = 0;
  logic [7:0] cur = '0, capb = '0;
  logic mdl_msb = 1'b1, mdl_cpha = 1'b0, prev_cs = 1'b1, prev_sclk = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic bitof(input logic [7:0] b, input int i, input logic msb);
    return msb ? b[7-i] : b[i];
  endfunction

  function automatic int half_of(input int div);
    int h = (div + 1) / 2;
    return (h == 0) ? 1 : h;
  endfunction

  task automatic gap_upd();
    int g = cyc - last_evt;
    if (g < gmin) gmin = g;
    if (g > gmax) gmax = g;
    last_evt = cyc;
  endtask

  task automatic next_slave_byte();
    cur = sl_q[sl_idx % 16];
    sl_idx++;
    if (!mdl_cpha) begin miso_r = bitof(cur, 0, mdl_msb); oi = 1; end
    else oi = 0;
  endtask

  // behavioural slave and edge monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = 1'b0;
    end else begin
      if (prev_cs && !cs_n) begin
        ec = 0; cs_falls++; last_evt = cyc;
        next_slave_byte();
      end else if (!prev_cs && cs_n) begin
        gap_upd();
      end else if (!cs_n && sclk !== prev_sclk) begin
        gap_upd();
        edges++;
        if (((ec % 2) == 0) != mdl_cpha) begin
          if (mdl_msb) capb[7 - ec/2] = mosi; else capb[ec/2] = mosi;
        end else if (mdl_cpha || ec != 15) begin
          miso_r = bitof(cur, oi, mdl_msb); oi++;
        end
        ec++;
        if (ec == 16) begin
          cap_q[n_cap % 16] = capb; n_cap++; ec = 0;
          next_slave_byte();
        end
      end
      if (rx_valid && rx_ready) begin rx_got[n_rx % 16] = rx_data; n_rx++; end
      prev_cs = cs_n; prev_sclk = sclk;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic prep(input logic [1:0] mode, input logic msb, input int div, input int disc);
    reg_write(2'd1, 32'h0);
    reg_write(2'd1, 32'(div));
    reg_write(2'd1, 32'h1_0000 | 32'(div));
    reg_write(2'd0, 32'h1 | (32'(msb) << 2) | (32'(mode) << 4) | (32'(disc) << 8));
    mdl_msb = msb; mdl_cpha = mode[0];
    n_cap = 0; n_rx = 0; sl_idx = 0; gmin = 1 << 30; gmax = 0; edges = 0; cs_falls = 0;
  endtask

  task automatic fill(input int nb);
    for (int i = 0; i < 16; i++) begin
      tx_q[i] = 8'($urandom); sl_q[i] = 8'($urandom);
    end
    if (nb > 1) begin tx_q[0] = 8'h81; sl_q[0] = 8'h0F; end
  endtask

  task automatic send(input int nb);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); tx_valid = 1'b1; tx_data = tx_q[i];
      #1;
      while (!tx_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input string tag, input int nb, input int disc, input int div,
                        input logic [1:0] mode, input logic gaps);
    chk({tag, " R5 byte count"}, n_cap, nb);
    for (int i = 0; i < nb; i++) chk({tag, " R4 R5 mosi byte"}, cap_q[i], tx_q[i]);
    chk({tag, " R8 rx count"}, n_rx, nb - disc);
    for (int i = 0; i < nb - disc; i++) chk({tag, " R4 R5 R8 rx byte"}, rx_got[i], sl_q[i + disc]);
    chk({tag, " R7 one cs pulse"}, cs_falls, 1);
    chk({tag, " R3 idle sclk"}, sclk, mode[1]);
    if (gaps) begin
      chk({tag, " R6 min half-period"}, gmin, half_of(div));
      chk({tag, " R6 max half-period"}, gmax, half_of(div));
    end
  endtask

  task automatic run_frame(input string tag, input logic [1:0] mode, input logic msb,
                           input int div, input int nb, input int disc);
    prep(mode, msb, div, disc);
    fill(nb);
    send(nb);
    wait_idle();
    verify(tag, nb, disc, div, mode, 1'b1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int seen_rdy, seen_cs, e0;
    logic s0, m0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", cs_n, 1'b1);
    chk("R1 sclk", sclk, 1'b0);
    chk("R1 rx_valid", rx_valid, 1'b0);
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), rd);
      chk("R1 register zero", rd, 32'h0);
    end

    // R2 start inhibited unless master=1, slave=0, enable=1
    reg_write(2'd1, 32'h1_0002);
    for (int k = 0; k < 2; k++) begin
      reg_write(2'd0, (k == 0) ? 32'h0 : 32'h3);
      seen_rdy = 0; seen_cs = 0;
      @(negedge clk); tx_valid = 1'b1; tx_data = 8'hA5;
      repeat (40) begin @(negedge clk); if (tx_ready) seen_rdy++; if (!cs_n) seen_cs++; end
      tx_valid = 1'b0;
      chk("R2 no tx_ready when inhibited", seen_rdy, 0);
      chk("R2 cs_n stays high when inhibited", seen_cs, 0);
    end
    reg_write(2'd0, 32'h337);
    reg_read(2'd0, rd);
    chk("R2 config readback", rd, 32'h337);

    // R10 divisor write ignored while enable set
    reg_write(2'd1, 32'h1_0005);
    reg_read(2'd1, rd);
    chk("R10 divisor guarded", rd, 32'h1_0002);

    // R3 R4 R5 R6 R7 every mode and order, random divisor and length
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++)
        run_frame("mode/order", 2'(m), b[0], int'($urandom_range(1, 7)),
                  int'($urandom_range(2, 5)), 0);

    // R6 divisor extremes
    run_frame("div0", 2'd0, 1'b1, 0, 3, 0);
    run_frame("div3ff", 2'd3, 1'b0, 10'h3FF, 1, 0);

    // R8 discard leading bytes
    run_frame("discard", 2'd1, 1'b1, 2, 4, 2);

    // R11 status and interrupt
    reg_read(2'd3, rd);
    chk("R11 status both set", rd, 32'h3);
    reg_write(2'd2, 32'h2);
    @(negedge clk); chk("R11 irq from frame end", irq, 1'b1);
    reg_write(2'd3, 32'h2);
    reg_read(2'd3, rd);
    chk("R11 write-one clears bit1 only", rd, 32'h1);
    chk("R11 irq cleared", irq, 1'b0);

    // R9 freeze by clearing the clock enable mid-byte
    prep(2'd2, 1'b1, 4, 0);
    fill(2);
    send(2);
    repeat (6) @(negedge clk);
    reg_write(2'd1, 32'h4);
    @(negedge clk);
    s0 = sclk; m0 = mosi; e0 = edges;
    repeat (60) @(negedge clk);
    chk("R9 sclk frozen", sclk, s0);
    chk("R9 mosi frozen", mosi, m0);
    chk("R9 no edges while frozen", edges, e0);
    chk("R9 cs_n held low", cs_n, 1'b0);
    reg_write(2'd1, 32'h1_0004);
    wait_idle();
    verify("freeze", 2, 0, 4, 2'd2, 1'b0);

    // R12 receive back-pressure
    prep(2'd0, 1'b1, 1, 0);
    fill(2);
    rx_ready = 1'b0;
    send(2);
    wait_idle();
    chk("R12 rx_valid held", rx_valid, 1'b1);
    chk("R12 rx_data first byte", rx_data, sl_q[0]);
    repeat (5) @(negedge clk);
    chk("R12 rx_data stable", rx_data, sl_q[0]);
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 second byte dropped", n_rx, 1);
    chk("R12 delivered byte", rx_got[0], sl_q[0]);
    chk("R12 rx_valid cleared", rx_valid, 1'b0);

    summary();
    $finish;
  end
endmodule